// File: doc/BRIEF.md
# Timer/Event Counter with Prescaler

This block is an 8-bit up-counter with a reload value. A control register selects what advances the counter. It can count transitions on an external pin. It can run as a timer on a divided copy of the system clock. It can also measure how long one pulse on the pin lasts. When the counter rolls past its all-ones value it reloads from the reload value and raises an interrupt request flag. The flag stays set until the interrupt logic clears it. Each rollover also flips a square-wave output that can drive a tone generator, and the pending flag doubles as a wake-up request.

Software reaches the block through a two-location register port. Location 0 is the counter and location 1 is the control register. Read data is always present for the selected location. Asserting the read strobe marks a real read access, and the counter holds still during that cycle. The system clock enable gates the divider, the pin synchronizer and all counting. Register writes and flag clears take effect on any clock edge. The port has no back-pressure: every access completes in the cycle it is presented.

Top module: `tmr_event_counter`

## Requirements
- R1: After reset the counter, the reload value, the control register, the request flag, the overflow pulse and the tone output are all zero.
- R2: An increment from FFh loads the reload value into the counter. At the same clock edge it sets the request flag, raises the overflow pulse for exactly one cycle and flips the tone output. The wake-up output follows the flag. A clear request lowers the flag unless an overflow happens in the same cycle.
- R3: Control bits 7:6 pick the source: 00 = nothing counts, 01 = pin events, 10 = divided clock, 11 = pulse-width measurement.
- R4: Control bits 2:0 hold n. The divider is a 7-bit counter that is cleared by reset and advances on every enabled cycle. An internal tick occurs on each enabled cycle in which the low n divider bits are all ones, so ticks come once every 2^n enabled cycles.
- R5: Control bit 4 enables counting. Control bit 3 picks the active pin edge (0 = rising, 1 = falling). Control bit 5 always reads 0. The register reads back as {mode[1:0], 0, enable, edge, n[2:0]}.
- R6: A write to location 0 while the enable bit is 0 loads both the counter and the reload value. While the enable bit is 1 it loads only the reload value. Such a write blocks counting for that cycle.
- R7: In pulse-width mode, measurement begins at the active pin edge. The counter advances on internal ticks while the measurement runs. At the opposite edge the counter stops and the enable bit clears by itself, and the result holds until software writes the control register again. An overflow during a measurement behaves as in R2.
- R8: In event and timer modes the enable bit changes only through a control write.
- R9: The counter does not change in a cycle where the read strobe is high and location 0 is selected.
- R10: The pin passes through two synchronizer flops before edge detection. In event mode each active edge adds one, and the counter changes at the third enabled clock edge after the pin changes.
- R11: While the clock enable is low, the divider, the synchronizer and the counter all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | System clock enable for divider, synchronizer and counting |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks a read access) |
| reg_sel | input | 1 | Location: 0 = counter, 1 = control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected location |
| ext_pin | input | 1 | Asynchronous external pin |
| irq_clr | input | 1 | Clears the request flag |
| ovf_pulse | output | 1 | One-cycle pulse after each overflow |
| irq_flag | output | 1 | Overflow interrupt request flag |
| tone_out | output | 1 | Flips on every overflow |
| wake_req | output | 1 | Wake-up indication while a request is pending |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 3-bit divider select and a two-stage synchronizer. With these values a full count from a preset near FFh takes only a few cycles. The slowest divider setting of 128 cycles per tick is also exercised, so rollover can be observed at every divider setting within a short run. The two-stage synchronizer gives a fixed three-edge latency from the pin to the counter, and a per-cycle reference model tracks that latency cycle by cycle in event and pulse-width modes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    TM_OFF   = 2'b00,
    TM_EVENT = 2'b01,
    TM_TIMER = 2'b10,
    TM_PULSE = 2'b11
  } tmr_mode_e;

  // bit order is the software view of the control location
  typedef struct packed {
    tmr_mode_e  mode;
    logic       rsvd;
    logic       run;
    logic       fall_sel;
    logic [2:0] psc;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sh_q <= '0;
    else if (ce) sh_q <= {sh_q[STAGES-1:0], pin};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  assign rise = ce &  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ce & ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  div_q <= '0;
    else if (ce) div_q <= div_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel));
  end

  assign tick = ce & (&(div_q | ~mask));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_cnt,
  input  logic         ld_pre,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] pre,
  output logic         wrap
);
  assign wrap = inc & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pre <= '0;
    end else begin
      if (ld_pre) pre <= wdata;
      if (ld_cnt)   cnt <= wdata;
      else if (inc) cnt <= wrap ? pre : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_event_counter.sv
module tmr_event_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_pin,
  input  logic              irq_clr,
  output logic              ovf_pulse,
  output logic              irq_flag,
  output logic              tone_out,
  output logic              wake_req
);
  localparam int unsigned SEL_W = 3;

  tmr_ctl_t         ctl_q;
  logic             meas_q;
  logic [CNT_W-1:0] cnt_q, pre_q;
  logic             rise, fall, tick, wrap, inc;
  logic             act_edge, end_edge, src;
  logic             cnt_wr, ctl_wr, rd_blk, pw_done;

  assign cnt_wr = reg_wr & ~reg_sel;
  assign ctl_wr = reg_wr &  reg_sel;
  assign rd_blk = reg_rd & ~reg_sel;

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce(clk_en), .pin(ext_pin),
    .rise(rise), .fall(fall)
  );

  tmr_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .ce(clk_en), .sel(ctl_q.psc), .tick(tick)
  );

  assign act_edge = ctl_q.fall_sel ? fall : rise;
  assign end_edge = ctl_q.fall_sel ? rise : fall;
  assign pw_done  = (ctl_q.mode == TM_PULSE) & ctl_q.run & meas_q & end_edge;

  always_comb begin
    unique case (ctl_q.mode)
      TM_EVENT: src = act_edge;
      TM_TIMER: src = tick;
      TM_PULSE: src = meas_q & tick & ~end_edge;
      default:  src = 1'b0;
    endcase
  end

  assign inc = ctl_q.run & src & ~rd_blk & ~cnt_wr;

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .ld_cnt(cnt_wr & ~ctl_q.run), .ld_pre(cnt_wr),
    .wdata(reg_wdata[CNT_W-1:0]), .inc(inc),
    .cnt(cnt_q), .pre(pre_q), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      meas_q <= 1'b0;
    end else if (ctl_wr) begin
      ctl_q  <= tmr_ctl_t'({reg_wdata[7:6], 1'b0, reg_wdata[4:0]});
      meas_q <= 1'b0;
    end else if (pw_done) begin
      ctl_q.run <= 1'b0;
      meas_q    <= 1'b0;
    end else if ((ctl_q.mode == TM_PULSE) && ctl_q.run && !meas_q && act_edge) begin
      meas_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_pulse <= 1'b0;
      irq_flag  <= 1'b0;
      tone_out  <= 1'b0;
    end else begin
      ovf_pulse <= wrap;
      irq_flag  <= wrap | (irq_flag & ~irq_clr);
      if (wrap) tone_out <= ~tone_out;
    end
  end

  assign wake_req  = irq_flag;
  assign reg_rdata = reg_sel ? DATA_W'(ctl_q) : DATA_W'(cnt_q);
endmodule

// File: rtl/tmr_event_counter_chk.sv
module tmr_event_counter_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             reg_sel,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             ovf_pulse,
  input logic             irq_flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] pre,
  input logic [1:0]       ctl_mode,
  input logic             ctl_run
);
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (cnt == pre) && irq_flag);

  p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode == 2'b00 && !(reg_wr && !reg_sel)) |=> cnt == $past(cnt));

  p_bit5_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> !reg_rdata[5]);

  p_run_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && ctl_run) |=> (pre == $past(reg_wdata[CNT_W-1:0])) && (cnt == $past(cnt)));

  p_sw_only_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && !(reg_wr && reg_sel) && ctl_mode != 2'b11) |=> ctl_run);

  p_read_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_sel && !reg_wr) |=> cnt == $past(cnt));
endmodule

bind tmr_event_counter tmr_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .ovf_pulse(ovf_pulse), .irq_flag(irq_flag), .cnt(cnt_q), .pre(pre_q),
  .ctl_mode(ctl_q.mode), .ctl_run(ctl_q.run)
);

// File: tb/tb_tmr_event_counter.sv
module tb_tmr_event_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ext_pin = 1'b0, irq_clr = 1'b0;
  logic       ovf_pulse, irq_flag, tone_out, wake_req;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  tmr_event_counter dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_pin(ext_pin), .irq_clr(irq_clr), .ovf_pulse(ovf_pulse),
    .irq_flag(irq_flag), .tone_out(tone_out), .wake_req(wake_req)
  );

  // behavioural reference state
  int m_s1, m_s2, m_prev, m_div, m_cnt, m_pre, m_mode, m_en, m_fall, m_psc;
  int m_meas, m_flag, m_ovf, m_tone;

  function automatic int ctl_val();
    return (m_mode << 6) | (m_en << 4) | (m_fall << 3) | m_psc;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int rise, fall, act, endg, tick, inc, cwr, ctlwr, blk, ovf, mask;
    cyc++;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_div = 0; m_cnt = 0; m_pre = 0;
      m_mode = 0; m_en = 0; m_fall = 0; m_psc = 0; m_meas = 0;
      m_flag = 0; m_ovf = 0; m_tone = 0;
    end else begin
      rise = (clk_en && m_s2 && !m_prev) ? 1 : 0;
      fall = (clk_en && !m_s2 && m_prev) ? 1 : 0;
      act  = m_fall ? fall : rise;
      endg = m_fall ? rise : fall;
      mask = (1 << m_psc) - 1;
      tick = (clk_en && ((m_div & mask) == mask)) ? 1 : 0;
      cwr   = (reg_wr && !reg_sel) ? 1 : 0;
      ctlwr = (reg_wr && reg_sel) ? 1 : 0;
      blk   = (reg_rd && !reg_sel) ? 1 : 0;
      case (m_mode)
        1: inc = act;
        2: inc = tick;
        3: inc = (m_meas && tick && !endg) ? 1 : 0;
        default: inc = 0;
      endcase
      if (!m_en || blk || cwr) inc = 0;
      ovf = (inc && m_cnt == 255) ? 1 : 0;
      if (cwr) begin
        if (!m_en) m_cnt = reg_wdata;
        m_pre = reg_wdata;
      end else if (inc) m_cnt = ovf ? m_pre : m_cnt + 1;
      if (ovf) m_flag = 1; else if (irq_clr) m_flag = 0;
      if (ovf) m_tone = 1 - m_tone;
      m_ovf = ovf;
      if (ctlwr) begin
        m_mode = reg_wdata[7:6]; m_en = reg_wdata[4]; m_fall = reg_wdata[3];
        m_psc = reg_wdata[2:0]; m_meas = 0;
      end else if (m_mode == 3 && m_en) begin
        if (m_meas && endg) begin m_meas = 0; m_en = 0; end
        else if (!m_meas && act) m_meas = 1;
      end
      if (clk_en) begin
        m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        m_div = (m_div + 1) % 128;
      end
      #2;
      chk({cur_req, " rdata"}, reg_rdata, reg_sel ? ctl_val() : m_cnt);
      chk("R2 flag", irq_flag, m_flag);
      chk("R2 pulse", ovf_pulse, m_ovf);
      chk("R2 tone", tone_out, m_tone);
      chk("R2 wake", wake_req, m_flag);
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    checks++; errors++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic peek(input string req, input logic sel, input int exp);
    reg_sel = sel; #1;
    chk(req, reg_rdata, exp);
    reg_sel = 1'b0;
  endtask

  initial begin
    idle(3);
    peek("R1 counter", 1'b0, 0);
    peek("R1 control", 1'b1, 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 tone", tone_out, 0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R3";                      // mode 00 with enable: no counting
    wr(1'b1, 8'h10);
    repeat (6) begin ext_pin = ~ext_pin; idle(3); end
    peek("R3 off count", 1'b0, 0);

    cur_req = "R6";                      // stopped write loads counter
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hF0);
    peek("R6 stopped load", 1'b0, 8'hF0);

    cur_req = "R4";                      // timer, n = 0, 2, 7
    wr(1'b1, 8'h90);
    idle(20);
    chk("R2 flag set", irq_flag, 1);
    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R2 flag cleared", irq_flag, 0);
    wr(1'b1, 8'h92);
    idle(80);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hFC);
    wr(1'b1, 8'h97);
    idle(600);

    cur_req = "R6";                      // running write only reloads
    wr(1'b1, 8'h90);
    wr(1'b0, 8'h10);
    idle(300);

    cur_req = "R9";
    @(negedge clk); reg_rd = 1'b1;
    idle(10);
    reg_rd = 1'b0;

    cur_req = "R8";
    idle(40);
    peek("R8 enable kept", 1'b1, 8'h90);

    cur_req = "R10";                     // event mode, both edges
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hFA);
    ext_pin = 1'b0; idle(4);
    wr(1'b1, 8'h50);
    repeat (12) begin ext_pin = ~ext_pin; idle(3); end
    wr(1'b1, 8'h58);
    repeat (12) begin ext_pin = ~ext_pin; idle(2); end
    ext_pin = 1'b0; idle(4);

    cur_req = "R7";                      // pulse width, rising start, n = 0
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hF8);
    wr(1'b1, 8'hD0);
    idle(5);
    ext_pin = 1'b1; idle(30);
    ext_pin = 1'b0; idle(10);
    peek("R7 enable cleared", 1'b1, 8'hC0);
    ext_pin = 1'b1; idle(10); ext_pin = 1'b0; idle(5);
    peek("R7 result held", 1'b0, m_cnt);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hD9);                     // falling start, n = 1, pin high now
    ext_pin = 1'b1; idle(6);
    ext_pin = 1'b0; idle(24);
    ext_pin = 1'b1; idle(8);
    peek("R7 fall enable cleared", 1'b1, 8'hC9);

    cur_req = "R11";
    wr(1'b1, 8'h91);
    repeat (40) begin clk_en = ~clk_en; idle(2); end
    clk_en = 1'b0; idle(10);
    wr(1'b1, 8'h50);
    ext_pin = 1'b1; idle(10);
    clk_en = 1'b1; idle(6);
    ext_pin = 1'b0; idle(4);

    cur_req = "R5";
    wr(1'b1, 8'hFF);
    peek("R5 bit5 zero", 1'b1, 8'hDF);
    wr(1'b1, 8'h00);
    idle(4);
    finish_run();
  end
endmodule